// File: doc/BRIEF.md
# Synchronous Byte Shifter with Programmable Shift Clock

This block moves one byte at a time over a two-wire synchronous link and has no start or stop bits. One pin carries a shift clock that the block generates. A second pin carries the data. In transmit mode the block drives the data pin, and in receive mode it releases the pin. The shift clock rests high between transfers. Each transfer is exactly eight clock pulses, least significant bit first.

The speed of the shift clock comes from a 15-bit divider. The divider counts either the system clock or the rising edges of an external clock pin, after that pin has been synchronised. The host side sees a parallel byte, a start strobe, a busy flag and a done flag. The divider value, the clock source and the direction are captured when a transfer is accepted. They hold until that transfer ends.

Top module: `ss_sync_shifter`

## Requirements
- R1: While reset is high, and in the cycle after it, the outputs are at rest: `sclk_o`=1, `busy`=0, `done`=0 and `sdata_oe`=0.
- R2: A transmit (`rx_sel`=0) drives `sdata_oe`=1 for the whole transfer. Bit 0 of `tx_byte` is on `sdata_o` before the first rising edge of `sclk_o`. Each later bit, in LSB-first order, appears in the same cycle as the rising edge that ends the previous bit.
- R3: A receive (`rx_sel`=1) keeps `sdata_oe`=0. The block samples `sdata_i` on each rising edge of `sclk_o`. The first bit sampled lands in bit 0 of `rx_byte`, and `rx_byte` updates in the cycle of the eighth rising edge.
- R4: On the internal source (`ext_src_sel`=0), each low half and each high half of `sclk_o` lasts max(D,1)+1 system clock cycles, where D is `div_val`. D=1 therefore gives a period of 4 cycles with a low time of 2. Any D≥2 gives a period of 2(D+1) cycles, which is 6 or more.
- R5: On the external source (`ext_src_sel`=1), a tick is a rising edge of `ext_clk_pin` seen through a two-stage synchroniser. Each half of `sclk_o`, apart from the first low half, lasts max(D,1)+1 ticks.
- R6: A transfer has exactly eight rising edges of `sclk_o`. In the cycle of the eighth rising edge, `busy` falls, `done` rises and `sdata_oe` falls, and `sclk_o` stays high.
- R7: `done` stays high until the next accepted start, which clears it.
- R8: A `start` pulse while `busy`=1 has no effect on the transfer in progress: its bits, its timing and its edge count are unchanged.
- R9: Changes to `div_val`, `ext_src_sel`, `rx_sel` or `tx_byte` during a transfer have no effect on it.
- R10: Between transfers `sclk_o` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transfer; taken only when idle |
| rx_sel | input | 1 | 1 = receive, 0 = transmit |
| ext_src_sel | input | 1 | 1 = divider counts the external clock pin |
| div_val | input | 15 | Divider value D |
| tx_byte | input | 8 | Byte to send |
| rx_byte | output | 8 | Last byte received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| ext_clk_pin | input | 1 | External divider clock |
| sclk_o | output | 1 | Shift clock pin |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe | output | 1 | Data pin output enable |
| sdata_i | input | 1 | Data pin input value |

## Verification
Two functions fall in the same cycle at the eighth rising edge of the shift clock. The final shift or sample happens there, and so does completion: busy falls, done rises and the data pin is released. The bench samples the ports at the falling clock edge in which the rising edge is first seen, and judges the received byte, `busy`, `done` and `sdata_oe` together at that same sample. A second collision comes from a start pulse, a new divider, a flipped source and a flipped direction, all applied together right after the third rising edge. That transfer must still finish with its original bits and half-period lengths.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } ss_phase_e;
endpackage

// File: rtl/ss_tick_src.sv
// Produces the divider tick: every cycle, or one cycle per synchronised
// rising edge of the external clock pin.
module ss_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_pin,
  input  logic use_ext,
  output logic tick
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= ext_pin;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign tick = use_ext ? (sync_q[LAST] & ~prev_q) : 1'b1;
endmodule

// File: rtl/ss_half_timer.sv
// Counts ticks within one half of the shift clock; limit latched on load.
module ss_half_timer #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);
  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (load) begin
      lim_q <= (div_in == '0) ? DIV_W'(1) : div_in;
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= expire ? '0 : cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/ss_shift_reg.sv
// Right-shifting register: bit 0 leaves first, new bits enter at the top.
module ss_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load)     q <= load_val;
    else if (shift_en) q <= {ser_in, q[W-1:1]};
  end
endmodule

// File: rtl/ss_sync_shifter.sv
module ss_sync_shifter #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rx_sel,
  input  logic              ext_src_sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic              done,
  input  logic              ext_clk_pin,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe,
  input  logic              sdata_i
);
  import ss_pkg::*;

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  ss_phase_e         phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic              rx_q;
  logic              src_q;
  logic              tick;
  logic              expire;
  logic              accept;
  logic              rise_evt;
  logic [DATA_W-1:0] sh_q;

  assign accept   = start && (phase_q == PH_IDLE);
  assign rise_evt = expire && (phase_q == PH_LOW);

  ss_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .ext_pin (ext_clk_pin),
    .use_ext (src_q),
    .tick    (tick)
  );

  ss_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .div_in (div_val),
    .run    (phase_q != PH_IDLE),
    .tick   (tick),
    .expire (expire)
  );

  ss_shift_reg #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (tx_byte),
    .shift_en (rise_evt),
    .ser_in   (sdata_i),
    .q        (sh_q)
  );

  assign sdata_o = sh_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      bit_q    <= '0;
      rx_q     <= 1'b0;
      src_q    <= 1'b0;
      sclk_o   <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      sdata_oe <= 1'b0;
      rx_byte  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q  <= PH_LOW;
            bit_q    <= '0;
            rx_q     <= rx_sel;
            src_q    <= ext_src_sel;
            sclk_o   <= 1'b0;
            busy     <= 1'b1;
            done     <= 1'b0;
            sdata_oe <= ~rx_sel;
          end
        end
        PH_LOW: begin
          if (expire) begin
            sclk_o <= 1'b1;
            if (bit_q == LAST_BIT) begin
              phase_q  <= PH_IDLE;
              busy     <= 1'b0;
              done     <= 1'b1;
              sdata_oe <= 1'b0;
              if (rx_q) rx_byte <= {sdata_i, sh_q[DATA_W-1:1]};
            end else begin
              phase_q <= PH_HIGH;
              bit_q   <= bit_q + BIT_W'(1);
            end
          end
        end
        PH_HIGH: begin
          if (expire) begin
            sclk_o  <= 1'b0;
            phase_q <= PH_LOW;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ss_sync_shifter_chk.sv
module ss_sync_shifter_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic rx_sel,
  input logic busy,
  input logic done,
  input logic sclk_o,
  input logic sdata_oe
);
  // R1: rest state right after reset
  a_r1_reset_rest: assert property (@(posedge clk)
    rst |=> (sclk_o && !busy && !done && !sdata_oe));

  // R6: completion is clean
  a_r6_done_clean: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (sclk_o && !busy && !sdata_oe));

  // R10: idle clock high
  a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk_o);

  // R7: done holds until a start
  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R3: receive never drives the data line
  a_r3_rx_released: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(rx_sel)) |-> !sdata_oe);

  // R2: line driven only inside a transfer
  a_r2_oe_in_xfer: assert property (@(posedge clk) disable iff (rst)
    sdata_oe |-> busy);

  // R4: every half lasts at least two cycles
  a_r4_low_min: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |=> !sclk_o);
endmodule

bind ss_sync_shifter ss_sync_shifter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .rx_sel   (rx_sel),
  .busy     (busy),
  .done     (done),
  .sclk_o   (sclk_o),
  .sdata_oe (sdata_oe)
);

// File: tb/sim_ss_sync_shifter.sv
module sim_ss_sync_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rx_sel = 1'b0;
  logic        ext_src_sel = 1'b0;
  logic [14:0] div_val = 15'd1;
  logic [7:0]  tx_byte = 8'd0;
  logic [7:0]  rx_byte;
  logic        busy, done;
  logic        ext_clk_pin = 1'b0;
  logic        sclk_o, sdata_o, sdata_oe;
  logic        sdata_i = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always #40 ext_clk_pin = ~ext_clk_pin;

  ss_sync_shifter u0 (
    .clk(clk), .rst(rst), .start(start), .rx_sel(rx_sel),
    .ext_src_sel(ext_src_sel), .div_val(div_val), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .busy(busy), .done(done), .ext_clk_pin(ext_clk_pin),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sdata_i(sdata_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit rx, input logic [7:0] txb, input logic [14:0] d,
                      input bit ext, input logic [7:0] slv, input int poke_rise);
    int  half_exp = ((d == 0) ? 1 : int'(d)) + 1;
    int  run = 1;
    int  rises = 0;
    int  guard = 0;
    bit  first_low = 1'b1;
    bit  oe_bad = 1'b0;
    bit  len_bad = 1'b0;
    logic [7:0] got = 8'h00;
    logic prev_s, prev_d;
    if (ext) half_exp = half_exp * 4;
    @(negedge clk);
    rx_sel = rx; tx_byte = txb; div_val = d; ext_src_sel = ext;
    sdata_i = rx ? slv[0] : 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(done == 1'b0, "R7 done cleared by start", done, 0);
    prev_s = sclk_o; prev_d = sdata_o;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
      start = 1'b0;
      if (prev_s == 1'b0 && sclk_o == 1'b1) begin
        rises++;
        if (!(ext && first_low) && run != half_exp) begin
          len_bad = 1'b1;
          chk(1'b0, ext ? "R5 low half" : "R4 low half", run, half_exp);
        end
        first_low = 1'b0;
        if (rises <= 8) got[rises-1] = prev_d;
        if (rx && rises < 8) sdata_i = slv[rises];
        run = 1;
        if (rises == poke_rise) begin
          start = 1'b1; tx_byte = ~txb; div_val = d + 15'd3;
          ext_src_sel = ~ext; rx_sel = ~rx;
        end
      end else if (prev_s == 1'b1 && sclk_o == 1'b0) begin
        if (run != half_exp) begin
          len_bad = 1'b1;
          chk(1'b0, ext ? "R5 high half" : "R4 high half", run, half_exp);
        end
        run = 1;
      end else begin
        run++;
      end
      if (busy && (sdata_oe != !rx)) oe_bad = 1'b1;
      prev_s = sclk_o; prev_d = sdata_o;
    end
    start = 1'b0;
    chk(guard < 20000, "R6 transfer ends", guard, 0);
    chk(!len_bad, ext ? "R5 half lengths" : "R4 half lengths", len_bad, 0);
    chk(!oe_bad, rx ? "R3 line released" : "R2 line driven", oe_bad, 0);
    chk(rises == 8, "R6 eight rising edges", rises, 8);
    chk(done == 1'b1 && sdata_oe == 1'b0 && sclk_o == 1'b1, "R6 completion same cycle",
        {done, sdata_oe, sclk_o}, 3'b101);
    if (rx) chk(rx_byte == slv, "R3 received byte", rx_byte, slv);
    else    chk(got == txb, "R2 transmitted bits", got, txb);
    if (poke_rise > 0) chk(rises == 8 && !len_bad, "R8 R9 start and config ignored", rises, 8);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R7 done holds", done, 1);
    chk(sclk_o == 1'b1 && busy == 1'b0, "R10 idle clock high", sclk_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_o == 1'b1 && busy == 1'b0 && done == 1'b0 && sdata_oe == 1'b0,
        "R1 reset state", {sclk_o, busy, done, sdata_oe}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk_o == 1'b1 && busy == 1'b0, "R10 idle after reset", sclk_o, 1);
    for (int di = 0; di < 5; di++) begin
      for (int bi = 0; bi < 7; bi++) begin
        logic [14:0] dv;
        logic [7:0]  bv;
        case (di) 0: dv = 0; 1: dv = 1; 2: dv = 2; 3: dv = 3; default: dv = 7; endcase
        case (bi) 0: bv = 8'h00; 1: bv = 8'hFF; 2: bv = 8'hA5; 3: bv = 8'h5A;
                  4: bv = 8'h01; 5: bv = 8'h80; default: bv = 8'h3C; endcase
        xfer(1'b0, bv, dv, 1'b0, 8'h00, 0);
        xfer(1'b1, 8'h00, dv, 1'b0, bv ^ 8'h96, 0);
      end
    end
    xfer(1'b0, 8'hC3, 15'd1, 1'b1, 8'h00, 0);
    xfer(1'b1, 8'h00, 15'd2, 1'b1, 8'h6D, 0);
    xfer(1'b0, 8'h9E, 15'd2, 1'b0, 8'h00, 3);
    xfer(1'b1, 8'h00, 15'd1, 1'b0, 8'hB2, 3);
    xfer(1'b0, 8'h47, 15'd1, 1'b1, 8'h00, 3);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule